// File: doc/BRIEF.md
# Banked Triangle Store with Single-Cycle Whole-Triangle Read

This block holds the triangle meshes of a moving object and its fixed surroundings for a collision-checking datapath. A triangle is nine 32-bit fixed-point coordinates (288 bits). The store returns the whole triangle in one read, one clock after the request, so a downstream intersection unit can take a new triangle every cycle.

The 288 bits are cut into eight 36-bit words. Storage is four 36-bit dual-port RAM banks. Each bank holds two words of every triangle. One word sits at address `t`, where `t` is the triangle index, and the other sits at the mirrored address `DEPTH-1-t`. A read drives the first read port of every bank at `t` and the second at the mirrored address, so all eight words arrive in the same cycle.

Loading is done one 36-bit word per cycle. Each write gives a triangle index and a word slot. The store counts accepted words and raises a flag once the configured number of triangles has been written.

Top module: `tri_store`

## Requirements
- R1: After reset `rd_valid` is 0. `load_done` is 0 whenever `cfg_tri_count` is nonzero.
- R2: A write (`wr_en`=1) stores `wr_data` as word slot `wr_slot` of triangle `wr_index`. Slot `s` goes to bank `s mod 4`, at address `wr_index` when `s`<4 and at `DEPTH-1-wr_index` when `s`>=4.
- R3: A read (`rd_req`=1) of triangle `rd_index` puts the whole triangle on `rd_triangle` in the next cycle. Word slot `s` occupies bits `[287-36*s -: 36]`, so coordinate `j` (x1,x2,x3,y1,y2,y3,z1,z2,z3 for j=0..8) occupies bits `[287-32*j -: 32]`.
- R4: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_req`=1, and 0 otherwise.
- R5: In a cycle after one with `rd_req`=0, `rd_triangle` keeps its previous value, even when writes change the stored data.
- R6: A read and a write to the same triangle in the same cycle return the data as it was before the write (read-before-write).
- R7: `load_done` is 1 exactly when the number of words accepted since reset is at least 8×`cfg_tri_count`. The word counter saturates at its maximum and never wraps.
- R8: All 256 triangle indices (0 to 255) are stored independently. The mirrored addresses never collide with the direct ones.
- R9: A cycle with `wr_en`=0 changes no stored data, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tri_count | input | 9 | Number of triangles expected in the load (0..256) |
| wr_en | input | 1 | Write one word this cycle |
| wr_index | input | 8 | Triangle index of the write |
| wr_slot | input | 3 | Word slot 0..7 within the triangle |
| wr_data | input | 36 | Word to store |
| rd_req | input | 1 | Read request |
| rd_index | input | 8 | Triangle index to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_triangle | output | 288 | Whole triangle, word slot 0 in the top bits |
| load_done | output | 1 | Configured number of triangles loaded |

## Verification
A write and a read can land on the same triangle in the same cycle, because the write path and both read ports share each bank. The bench fills all 256 triangles, sweeps every one back to back, and then issues a read of one triangle together with a write to one of its words. It expects the pre-write words in the next cycle and the new word on a later read. It also holds reads idle while writing, and expects the output to stay frozen in that time.

// File: rtl/tri_store_pkg.sv
package tri_store_pkg;
    localparam int DEF_COORD_W = 32;
    localparam int DEF_WORD_W  = 36;
    localparam int DEF_DEPTH   = 512;

    // Coordinates per triangle: three vertices of three axes.
    localparam int COORDS_PER_TRI = 9;

    // Address of the second word of a triangle in a bank: mirrored from the top.
    function automatic int unsigned mirror_addr(input int unsigned idx, input int unsigned depth);
        return depth - 1 - idx;
    endfunction
endpackage

// File: rtl/tri_bank.sv
module tri_bank #(
    parameter int WORD_W = 36,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [WORD_W-1:0] rdata_a,
    output logic [WORD_W-1:0] rdata_b
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Reads see the array before this edge's write: read-before-write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata_a <= mem[raddr_a];
            rdata_b <= mem[raddr_b];
        end
    end
endmodule

// File: rtl/tri_addr_map.sv
module tri_addr_map #(
    parameter int DEPTH  = 512,
    parameter int NBANK  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int IW    = $clog2(DEPTH / 2),
    localparam int SW    = $clog2(2 * NBANK),
    localparam int BW    = $clog2(NBANK)
) (
    input  logic [IW-1:0]    wr_index,
    input  logic [SW-1:0]    wr_slot,
    input  logic [IW-1:0]    rd_index,
    output logic [NBANK-1:0] bank_sel,
    output logic [AW-1:0]    waddr,
    output logic [AW-1:0]    raddr_a,
    output logic [AW-1:0]    raddr_b
);
    import tri_store_pkg::*;

    logic [BW-1:0] bank_idx;
    logic          upper_half;

    always_comb begin
        bank_idx   = wr_slot[BW-1:0];
        upper_half = wr_slot[SW-1];
        bank_sel   = '0;
        bank_sel[bank_idx] = 1'b1;
        if (upper_half) begin
            waddr = AW'(mirror_addr(int'(wr_index), DEPTH));
        end else begin
            waddr = AW'(wr_index);
        end
        raddr_a = AW'(rd_index);
        raddr_b = AW'(mirror_addr(int'(rd_index), DEPTH));
    end
endmodule

// File: rtl/tri_store.sv
module tri_store #(
    parameter int COORD_W  = tri_store_pkg::DEF_COORD_W,
    parameter int WORD_W   = tri_store_pkg::DEF_WORD_W,
    parameter int DEPTH    = tri_store_pkg::DEF_DEPTH,
    localparam int TRI_W   = tri_store_pkg::COORDS_PER_TRI * COORD_W,
    localparam int WORDS   = TRI_W / WORD_W,
    localparam int NBANK   = WORDS / 2,
    localparam int MAX_TRI = DEPTH / 2,
    localparam int IW      = $clog2(MAX_TRI),
    localparam int SW      = $clog2(WORDS),
    localparam int AW      = $clog2(DEPTH),
    localparam int CFG_W   = IW + 1,
    localparam int CW      = CFG_W + SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_tri_count,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_index,
    input  logic [SW-1:0]     wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [IW-1:0]     rd_index,
    output logic              rd_valid,
    output logic [TRI_W-1:0]  rd_triangle,
    output logic              load_done
);
    typedef struct packed {
        logic [CW-1:0] words;
        logic          rd_vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NBANK-1:0] bank_sel;
    logic [AW-1:0]    waddr, raddr_a, raddr_b;
    logic [WORD_W-1:0] q_a [NBANK];
    logic [WORD_W-1:0] q_b [NBANK];

    tri_addr_map #(.DEPTH(DEPTH), .NBANK(NBANK)) i_map (
        .wr_index (wr_index),
        .wr_slot  (wr_slot),
        .rd_index (rd_index),
        .bank_sel (bank_sel),
        .waddr    (waddr),
        .raddr_a  (raddr_a),
        .raddr_b  (raddr_b)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        tri_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_bank (
            .clk     (clk),
            .we      (wr_en && bank_sel[b]),
            .waddr   (waddr),
            .wdata   (wr_data),
            .re      (rd_req),
            .raddr_a (raddr_a),
            .raddr_b (raddr_b),
            .rdata_a (q_a[b]),
            .rdata_b (q_b[b])
        );
        // Slot b from the direct port, slot b+NBANK from the mirrored port.
        assign rd_triangle[TRI_W-1-WORD_W*b -: WORD_W]           = q_a[b];
        assign rd_triangle[TRI_W-1-WORD_W*(b+NBANK) -: WORD_W]   = q_b[b];
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rd_vld = rd_req;
        if (wr_en && (ctl_q.words != {CW{1'b1}})) begin
            ctl_d.words = ctl_q.words + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_valid  = ctl_q.rd_vld;
    assign load_done = (ctl_q.words >= {cfg_tri_count, {SW{1'b0}}});
endmodule

// File: rtl/tri_store_chk.sv
module tri_store_chk #(
    parameter int TRI_W = 288,
    parameter int CFG_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             rd_valid,
    input logic [TRI_W-1:0] rd_triangle,
    input logic             wr_en,
    input logic [CFG_W-1:0] cfg_tri_count,
    input logic             load_done
);
    // R4: valid follows a request by exactly one cycle
    assert_valid_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    assert_no_valid_without_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    // R5: output frozen when no read was requested
    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_triangle));
    // R7: flag does not drop while the configured count is unchanged
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_done) && $stable(cfg_tri_count) |-> load_done);
    // R7: flag only rises after a write or a change of the configured count
    assert_done_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> ($past(wr_en) || !$stable(cfg_tri_count)));
endmodule

bind tri_store tri_store_chk #(.TRI_W(TRI_W), .CFG_W(CFG_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_req        (rd_req),
    .rd_valid      (rd_valid),
    .rd_triangle   (rd_triangle),
    .wr_en         (wr_en),
    .cfg_tri_count (cfg_tri_count),
    .load_done     (load_done)
);

// File: tb/test_tri_store.sv
module test_tri_store;
    localparam int NT = 256;
    localparam int NW = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [8:0]   cfg_tri_count;
    logic         wr_en;
    logic [7:0]   wr_index;
    logic [2:0]   wr_slot;
    logic [35:0]  wr_data;
    logic         rd_req;
    logic [7:0]   rd_index;
    logic         rd_valid;
    logic [287:0] rd_triangle;
    logic         load_done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [35:0] model [NT][NW];

    always #5 clk = ~clk;

    tri_store i_tri_store (
        .clk(clk), .rst_n(rst_n), .cfg_tri_count(cfg_tri_count),
        .wr_en(wr_en), .wr_index(wr_index), .wr_slot(wr_slot), .wr_data(wr_data),
        .rd_req(rd_req), .rd_index(rd_index), .rd_valid(rd_valid),
        .rd_triangle(rd_triangle), .load_done(load_done)
    );

    function automatic logic [35:0] pat(input int t, input int s, input int seed);
        return {3'(s), 1'b1, 8'(t), 24'(t * 37 + s * 101 + seed)};
    endfunction

    function automatic logic [287:0] expect_tri(input int t);
        logic [287:0] v;
        for (int s = 0; s < NW; s++) v[287 - 36 * s -: 36] = model[t][s];
        return v;
    endfunction

    task automatic chk1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_tri(input string req, input logic [287:0] act, input logic [287:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input int t, input int s, input logic [35:0] d);
        wr_en = 1'b1; wr_index = 8'(t); wr_slot = 3'(s); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[t][s] = d;
    endtask

    task automatic read_check(input int t, input string req);
        logic [287:0] exp;
        exp = expect_tri(t);
        rd_req = 1'b1; rd_index = 8'(t);
        @(negedge clk);
        rd_req = 1'b0;
        chk1({req, " R4 valid"}, rd_valid, 1'b1);
        chk_tri(req, rd_triangle, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [287:0] held;
        logic [287:0] old5;
        rst_n = 1'b0; cfg_tri_count = 9'd2; wr_en = 1'b0; wr_index = '0;
        wr_slot = '0; wr_data = '0; rd_req = 1'b0; rd_index = '0;
        repeat (3) @(negedge clk);
        chk1("R1 rd_valid in reset", rd_valid, 1'b0);
        chk1("R1 load_done in reset", load_done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk1("R1 rd_valid after reset", rd_valid, 1'b0);
        chk1("R1 load_done after reset", load_done, 1'b0);

        // R7: threshold 2 triangles = 16 words
        for (int w = 0; w < 16; w++) begin
            write_word(w / NW, w % NW, pat(w / NW, w % NW, 0));
            if (w == 14) chk1("R7 below threshold", load_done, 1'b0);
        end
        chk1("R7 at threshold", load_done, 1'b1);
        cfg_tri_count = 9'd256;
        #1 chk1("R7 raised threshold", load_done, 1'b0);

        // R2/R8: fill remaining triangles
        for (int t = 2; t < NT; t++)
            for (int s = 0; s < NW; s++)
                write_word(t, s, pat(t, s, 0));
        chk1("R7 full load", load_done, 1'b1);

        // R3/R8: back-to-back sweep of every triangle
        for (int t = 0; t < NT; t++) read_check(t, "R8 R3 sweep");
        @(negedge clk);
        chk1("R4 idle after read", rd_valid, 1'b0);

        // R3: coordinate placement check on triangle 255
        read_check(255, "R3 order");
        chk1("R3 x1 top bits", rd_triangle[287:256] == {3'(0), 1'b1, 8'd255, 20'(pat(255, 0, 0) >> 4)}, 1'b1);

        // R5: output holds while writes change storage
        held = rd_triangle;
        for (int s = 0; s < NW; s++) write_word(255, s, pat(255, s, 7));
        chk_tri("R5 hold during writes", rd_triangle, held);
        chk1("R5 R4 no valid", rd_valid, 1'b0);
        read_check(255, "R2 rewrite");

        // R6: read and write of the same triangle in one cycle
        old5 = expect_tri(5);
        rd_req = 1'b1; rd_index = 8'd5;
        wr_en = 1'b1; wr_index = 8'd5; wr_slot = 3'd6; wr_data = 36'h5A5A5A5A5;
        @(negedge clk);
        rd_req = 1'b0; wr_en = 1'b0;
        model[5][6] = 36'h5A5A5A5A5;
        chk_tri("R6 old data returned", rd_triangle, old5);
        read_check(5, "R6 new data later");

        // R9: inactive write inputs change nothing
        wr_en = 1'b0; wr_index = 8'd0; wr_slot = 3'd7; wr_data = 36'hFFFFFFFFF;
        repeat (2) @(negedge clk);
        read_check(0, "R9 wr_en low");

        // R8: mirror boundary slots on the first and last triangles
        write_word(0, 4, 36'h111111111);
        write_word(255, 7, 36'h222222222);
        read_check(0, "R8 slot4 idx0");
        read_check(255, "R8 slot7 idx255");
        read_check(128, "R8 middle");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule